// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector Unit

This block gathers the event pulses of an I2C bus engine into sticky flags and turns them into a single interrupt line for the host. The flagged events are arbitration lost, missing acknowledge, access ready, receive data ready, transmit data ready, stop detected and addressed as slave. A per-event enable register selects which flags may raise the interrupt. The host works through a 16-bit register port: it reads raw flags from a status word, programs the enable word, and reads a vector word that names one pending, enabled event by a 3-bit code.

A vector read also consumes the event it reports. An interrupt handler can therefore loop on vector reads until it gets zero, handling one event per read in a fixed priority order. The status word also carries a bus-busy flag and a live copy of the receive-shift-register-full level. The bus-busy flag follows START and STOP pulses from the bus engine.

Top module: `i2cev_unit`

## Requirements
- R1: After reset the status, enable and vector words all read 0 and `irq` is low.
- R2: A one-cycle pulse on `ev_pulse[i]` sets a sticky flag whether or not it is enabled. The flag shows in status bit i, where i is 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected and 6 addressed as slave.
- R3: The enable word is at offset 0x04 and uses the same bit order as R2. Bits 6:0 are writable and bits 15:7 always read 0.
- R4: `irq` is high exactly when some flag is set and its enable bit is also set.
- R5: A read at offset 0x28 returns i+1 for the lowest index i whose flag and enable bit are both set. It returns 0 when no such i exists, and bits 15:3 are always 0.
- R6: A vector read clears only the flag it reports. Flags that are disabled, or that have a higher code, keep their state.
- R7: The status word is at offset 0x08. Writing 1 to status bit 2 or bit 5 clears that flag. Writing to any other bit of the status word, or writing 0, changes no flag.
- R8: Status bit 12 (bus busy) is set by a `bus_start` pulse and cleared by a `bus_stop` pulse. Register writes do not change it.
- R9: Status bit 11 reflects the level of `rx_shift_full` at the read.
- R10: If an event pulse and a clear of the same flag arrive in the same cycle, the flag stays set.
- R11: A read at any offset other than 0x04, 0x08 or 0x28 returns 0. Read data appears on `reg_rdata` one clock after the cycle in which `reg_rd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 7 | One-cycle event pulses, bit order as in R2 |
| bus_start | input | 1 | START seen on the bus (pulse) |
| bus_stop | input | 1 | STOP seen on the bus (pulse) |
| rx_shift_full | input | 1 | Receive shift register full (level) |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request to the host |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that every strobe and event pulse is sampled on a clean clock edge, so that a rising `irq` always traces back to an event or an enable write one cycle earlier. The bench drives all inputs on falling edges and issues one register access per cycle. It raises events and clears in the same cycle only in the deliberate collision case of R10.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int NUM_SRC  = 7;
  localparam int CODE_W   = $clog2(NUM_SRC + 1);

  localparam int OFF_ENABLE = 'h04;
  localparam int OFF_STATUS = 'h08;
  localparam int OFF_VECTOR = 'h28;

  // Status bit positions whose meaning a reader decodes.
  localparam int BIT_ACC_RDY = 2;
  localparam int BIT_STOPDET = 5;
  localparam int BIT_RSFULL  = 11;
  localparam int BIT_BUSY    = 12;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_ENABLE,
    ACC_STATUS,
    ACC_VECTOR
  } acc_target_e;
endpackage

// File: rtl/i2cev_flags.sv
module i2cev_flags #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flags_o
);
  logic [NSRC-1:0] flag_q, flag_d;
  logic            flag_en;

  // A new event wins over a clear in the same cycle.
  always_comb begin
    flag_en = (|set_i) | (|clr_i);
    flag_d  = (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/i2cev_prio.sv
module i2cev_prio #(
  parameter int NSRC = 7,
  parameter int CW   = 3
) (
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] grant_o,
  output logic [CW-1:0]   code_o
);
  logic [NSRC:0] seen;

  assign seen[0] = 1'b0;

  // The lowest index wins: a ripple of "already claimed" bits.
  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign grant_o[g]  = req_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req_i[g];
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant_o[i]) code_o = code_o | CW'(i + 1);
    end
  end
endmodule

// File: rtl/i2cev_busy.sv
module i2cev_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o
);
  logic busy_q, busy_d, busy_en;

  always_comb begin
    busy_en = start_i | stop_i;
    busy_d  = start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2cev_regif.sv
module i2cev_regif
  import i2cev_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int NSRC = NUM_SRC,
  parameter int CW   = CODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] flags_i,
  input  logic            busy_i,
  input  logic            rsfull_i,
  input  logic [CW-1:0]   vcode_i,
  input  logic [NSRC-1:0] vgrant_i,
  output logic [NSRC-1:0] enable_o,
  output logic [NSRC-1:0] clr_o,
  output logic [DW-1:0]   rdata_o
);
  localparam logic [NSRC-1:0] W1C_BITS =
    NSRC'((1 << BIT_ACC_RDY) | (1 << BIT_STOPDET));

  acc_target_e     tgt;
  logic [NSRC-1:0] en_q, en_d;
  logic            en_we;
  logic [DW-1:0]   rd_q, rd_d;
  logic [DW-1:0]   stat_word;

  always_comb begin
    if (addr_i == AW'(OFF_ENABLE))      tgt = ACC_ENABLE;
    else if (addr_i == AW'(OFF_STATUS)) tgt = ACC_STATUS;
    else if (addr_i == AW'(OFF_VECTOR)) tgt = ACC_VECTOR;
    else                                tgt = ACC_NONE;
  end

  always_comb begin
    en_we = wr_i && (tgt == ACC_ENABLE);
    en_d  = wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_comb begin
    clr_o = '0;
    if (wr_i && (tgt == ACC_STATUS)) clr_o = clr_o | (wdata_i[NSRC-1:0] & W1C_BITS);
    if (rd_i && (tgt == ACC_VECTOR)) clr_o = clr_o | vgrant_i;
  end

  always_comb begin
    stat_word                = '0;
    stat_word[NSRC-1:0]      = flags_i;
    stat_word[BIT_RSFULL]    = rsfull_i;
    stat_word[BIT_BUSY]      = busy_i;
  end

  always_comb begin
    unique case (tgt)
      ACC_ENABLE: rd_d = DW'(en_q);
      ACC_STATUS: rd_d = stat_word;
      ACC_VECTOR: rd_d = DW'(vcode_i);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_q <= '0;
    else if (rd_i) rd_q <= rd_d;
  end

  assign enable_o = en_q;
  assign rdata_o  = rd_q;
endmodule

// File: rtl/i2cev_unit.sv
module i2cev_unit
  import i2cev_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  ev_pulse,
  input  logic                bus_start,
  input  logic                bus_stop,
  input  logic                rx_shift_full,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] flag_clr;
  logic [NUM_SRC-1:0] pend_en;
  logic [NUM_SRC-1:0] vec_grant;
  logic [CODE_W-1:0]  vec_code;
  logic               busy_q;

  i2cev_flags #(.NSRC(NUM_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ev_pulse),
    .clr_i   (flag_clr),
    .flags_o (flag_q)
  );

  assign pend_en = flag_q & enable_q;

  i2cev_prio #(.NSRC(NUM_SRC), .CW(CODE_W)) u_prio (
    .req_i   (pend_en),
    .grant_o (vec_grant),
    .code_o  (vec_code)
  );

  i2cev_busy u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (bus_start),
    .stop_i  (bus_stop),
    .busy_o  (busy_q)
  );

  i2cev_regif #(
    .DW(DATA_W), .AW(ADDR_W), .NSRC(NUM_SRC), .CW(CODE_W)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (reg_addr),
    .wr_i     (reg_wr),
    .rd_i     (reg_rd),
    .wdata_i  (reg_wdata),
    .flags_i  (flag_q),
    .busy_i   (busy_q),
    .rsfull_i (rx_shift_full),
    .vcode_i  (vec_code),
    .vgrant_i (vec_grant),
    .enable_o (enable_q),
    .clr_o    (flag_clr),
    .rdata_o  (reg_rdata)
  );

  assign irq = |pend_en;
endmodule

// File: rtl/i2cev_chk.sv
module i2cev_chk
  import i2cev_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_SRC-1:0]  ev_pulse,
  input logic                bus_start,
  input logic                bus_stop,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic                irq,
  input logic [NUM_SRC-1:0]  flags,
  input logic                busy
);
  logic vec_rd, en_wr;
  assign vec_rd = reg_rd && (reg_addr == ADDR_W'(OFF_VECTOR));
  assign en_wr  = reg_wr && (reg_addr == ADDR_W'(OFF_ENABLE));

  // R2
  a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_pulse) |=> ((flags & $past(ev_pulse)) == $past(ev_pulse)));

  // R4
  a_r4_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|ev_pulse) || en_wr));

  // R5
  a_r5_vector_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> (reg_rdata[DATA_W-1:CODE_W] == '0));

  // R6
  a_r6_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> ($countones($past(flags) & ~flags) <= 1));

  // R7
  a_r7_al_only_by_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(vec_rd));

  // R8
  a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> busy);

  a_r8_busy_off_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !bus_start) |=> !busy);
endmodule

bind i2cev_unit i2cev_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_pulse  (ev_pulse),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .flags     (flag_q),
  .busy      (busy_q)
);

// File: tb/sim_i2cev_unit.sv
module sim_i2cev_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  ev_pulse;
  logic        bus_start, bus_stop, rx_shift_full;
  logic [5:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq;

  always #5 clk = ~clk;

  i2cev_unit u0 (.*);

  // Model built from the requirements
  logic [6:0] m_flags, m_en;
  logic       m_busy, m_rsfull;

  logic [15:0] q_exp[$];
  string       q_tag[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] stat_exp();
    logic [15:0] s = '0;
    s[6:0] = m_flags;
    s[11]  = m_rsfull;
    s[12]  = m_busy;
    return s;
  endfunction

  function automatic logic [2:0] vec_exp();
    logic [6:0] p = m_flags & m_en;
    for (int i = 0; i < 7; i++) if (p[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  // Monitor: pops one expectation per read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (q_exp.size() == 0) chk(reg_rdata, 16'hxxxx, "scoreboard-empty");
        else chk(reg_rdata, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic op_pulse(input logic [6:0] ev);
    ev_pulse = ev;
    m_flags  = m_flags | ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic op_write(input logic [5:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    if (a == 6'h04) m_en = d[6:0];
    if (a == 6'h08) m_flags = m_flags & ~(d[6:0] & 7'h24);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic op_read(input logic [5:0] a, input string tag);
    logic [15:0] e;
    logic [2:0]  v;
    case (a)
      6'h04:   e = {9'd0, m_en};
      6'h08:   e = stat_exp();
      6'h28: begin
        v = vec_exp();
        e = {13'd0, v};
        if (v != 0) m_flags[v-1] = 1'b0;
      end
      default: e = '0;
    endcase
    q_exp.push_back(e); q_tag.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    chk({15'd0, irq}, {15'd0, |(m_flags & m_en)}, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; ev_pulse = '0; bus_start = 0; bus_stop = 0; rx_shift_full = 0;
    reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    m_flags = '0; m_en = '0; m_busy = 0; m_rsfull = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 reset state
    chk_irq("R1 irq after reset");
    op_read(6'h08, "R1 status after reset");
    op_read(6'h04, "R1 enable after reset");
    op_read(6'h28, "R1 vector after reset");

    // R2 each event sets its status bit even when disabled; R4 stays low
    for (int i = 0; i < 7; i++) begin
      op_pulse(7'(1 << i));
      op_read(6'h08, "R2 status bit position");
    end
    chk_irq("R4 irq low while all disabled");
    op_read(6'h28, "R5 vector zero while disabled");

    // R3 enable register
    op_write(6'h04, 16'hFFFF);
    op_read(6'h04, "R3 enable upper bits read zero");
    chk_irq("R4 irq high once enabled");

    // R5/R6 walk through all codes
    for (int i = 0; i < 8; i++) op_read(6'h28, "R5 R6 vector walk");
    op_read(6'h08, "R6 all flags consumed");
    chk_irq("R4 irq low after walk");

    // R6 disabled flag untouched by vector read
    op_write(6'h04, 16'h0020);
    op_pulse(7'h24);
    chk_irq("R4 irq with partial enable");
    op_read(6'h28, "R6 vector skips disabled source");
    op_read(6'h08, "R6 disabled flag kept");
    op_read(6'h28, "R5 zero after enabled consumed");

    // R7 write-one-to-clear on bits 2 and 5 only
    op_pulse(7'h3F);
    op_write(6'h08, 16'h001B);
    op_read(6'h08, "R7 non-clearable bits unchanged");
    op_write(6'h08, 16'h0000);
    op_read(6'h08, "R7 zero write no effect");
    op_write(6'h08, 16'h0004);
    op_read(6'h08, "R7 access-ready cleared");
    op_write(6'h08, 16'h0020);
    op_read(6'h08, "R7 stop-detected cleared");

    // R10 collision: event wins over clear
    reg_addr = 6'h08; reg_wdata = 16'h0004; reg_wr = 1'b1; ev_pulse = 7'h04;
    m_flags = m_flags | 7'h04;
    @(negedge clk);
    reg_wr = 1'b0; ev_pulse = '0;
    op_read(6'h08, "R10 flag survives collision");

    // R8 bus busy
    bus_start = 1'b1; m_busy = 1'b1;
    @(negedge clk); bus_start = 1'b0;
    op_read(6'h08, "R8 busy set by start");
    op_write(6'h08, 16'h1000);
    op_read(6'h08, "R8 busy immune to write");
    bus_stop = 1'b1; m_busy = 1'b0;
    @(negedge clk); bus_stop = 1'b0;
    op_read(6'h08, "R8 busy cleared by stop");

    // R9 receive shift full level
    rx_shift_full = 1'b1; m_rsfull = 1'b1;
    op_read(6'h08, "R9 rsfull high");
    rx_shift_full = 1'b0; m_rsfull = 1'b0;
    op_read(6'h08, "R9 rsfull low");

    // R11 unmapped offsets
    op_read(6'h0C, "R11 unmapped reads zero");
    op_read(6'h2C, "R11 unmapped reads zero");

    // R5 priority with mixed pending set
    op_write(6'h04, 16'h007F);
    op_pulse(7'h50);
    op_read(6'h28, "R5 priority mixed");
    op_read(6'h28, "R5 priority mixed");
    op_read(6'h28, "R5 priority mixed");
    op_read(6'h28, "R5 priority mixed");
    chk_irq("R4 irq mixed");

    repeat (3) idle();
    if (q_exp.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d left expected 0", q_exp.size());
    end
    summary();
  end
endmodule